// File: doc/BRIEF.md
# Reservation Station Pool with Tag Wakeup

This block is a small pool of waiting operations for a single execution unit in an out-of-order core. An upstream issue stage hands over one operation per cycle. Each operation carries an opcode and two source operands. A source operand is either a value that is already known or the tag of the station that will produce that value. The pool places the operation in a free slot and tells the issuer which tag that slot stands for. It refuses new work while every slot is occupied.

The pool listens to one result broadcast bus. A waiting operand whose tag equals the broadcast tag takes the broadcast value. An operation whose operands both hold values becomes a candidate for the unit, and the pool offers exactly one candidate per cycle, always the one that has waited longest. The offered slot is then marked as executing. It stays occupied until its own tag appears on the broadcast bus, and at that point it is freed for reuse.

Top module: `rs_pool`

## Requirements
- R1: After a synchronous active-low reset, every slot is free: `iss_ready` is 1, `iss_tag` equals `TAG_BASE` and `dsp_valid` is 0.
- R2: An issued operation goes into the lowest-numbered free slot. `iss_tag` reports `TAG_BASE` plus that slot's index. `iss_ready` is 0 when all slots are occupied, and an `iss_valid` while `iss_ready` is 0 changes no slot.
- R3: An operation issued with both operands ready is offered on the dispatch outputs in the cycle after the issue edge, never in the issue cycle, with its opcode, slot tag and both values unchanged.
- R4: A waiting operand (`*_rdy` = 0) captures `bc_data` at an edge where `bc_valid` is 1 and `bc_tag` equals its tag. A broadcast with any other tag leaves it waiting.
- R5: An operand that arrives waiting on a tag that is being broadcast in the same issue cycle is stored with the broadcast value, as if it had been ready.
- R6: A slot is offered for dispatch only when both of its operands hold values.
- R7: A slot whose last operand is captured at an edge is offered no earlier than the cycle following that edge.
- R8: When several slots are candidates, the one issued earliest is offered, whatever its slot index.
- R9: Only one slot is offered per cycle. A slot that has been offered is not offered again before it is freed.
- R10: A broadcast carrying an occupied slot's own tag frees that slot at that edge, so `iss_ready` and `iss_tag` reflect it in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | An operation is offered for issue |
| iss_op | input | OP_W | Opcode of the issued operation |
| iss_a_rdy | input | 1 | First operand holds a value (1) or waits on a tag (0) |
| iss_a_tag | input | TAG_W | Producer tag of the first operand when waiting |
| iss_a_val | input | DATA_W | Value of the first operand when ready |
| iss_b_rdy | input | 1 | Second operand holds a value (1) or waits on a tag (0) |
| iss_b_tag | input | TAG_W | Producer tag of the second operand when waiting |
| iss_b_val | input | DATA_W | Value of the second operand when ready |
| iss_ready | output | 1 | At least one slot is free |
| iss_tag | output | TAG_W | Tag of the slot the next issue will take |
| bc_valid | input | 1 | A result is on the broadcast bus |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_data | input | DATA_W | Value of the broadcast result |
| dsp_valid | output | 1 | An operation is offered to the unit this cycle |
| dsp_op | output | OP_W | Opcode of the offered operation |
| dsp_tag | output | TAG_W | Slot tag of the offered operation |
| dsp_a | output | DATA_W | First operand value |
| dsp_b | output | DATA_W | Second operand value |

## Verification
The pool is tried first with an operation whose operands are all ready. This separates correct one-cycle dispatch timing from a same-cycle or a repeated dispatch. It is then filled with operations that wait on external tags, and the broadcasts include a tag that nothing waits for. This separates tag-matched capture from blind capture, and the full pool shows that issue is refused. A later pattern frees a low-index slot and reissues into it while an older operation sits in a higher slot. Both are then woken by one broadcast, which also matches a newly issued operand. This separates oldest-first selection from lowest-index selection and also covers capture in the issue cycle.

// File: rtl/rs_pool_pkg.sv
// Shared widths, operand type and the broadcast snoop helper for the pool.
// Assumes tags and values fit the widths declared here.
package rs_pool_pkg;
    parameter int unsigned TAG_W  = 3;
    parameter int unsigned DATA_W = 16;
    parameter int unsigned OP_W   = 2;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [OP_W-1:0]   op_t;

    // One source slot: a value when rdy is set, otherwise a producer tag.
    typedef struct packed {
        logic  rdy;
        tag_t  tag;
        data_t val;
    } opnd_t;

    // Returns the operand after one broadcast has been observed.
    function automatic opnd_t snoop(opnd_t o, logic v, tag_t t, data_t d);
        opnd_t r;
        r = o;
        if (!o.rdy && v && (o.tag == t)) begin
            r.rdy = 1'b1;
            r.val = d;
        end
        return r;
    endfunction
endpackage

// File: rtl/rs_slot.sv
// One station slot: holds an opcode and two operands, wakes operands from
// the broadcast bus, marks itself executing once dispatched and frees itself
// when its own tag is broadcast. Assumes wr_en only when the slot is free.
module rs_slot
    import rs_pool_pkg::*;
#(
    parameter tag_t MY_TAG = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  op_t   wr_op,
    input  opnd_t wr_a,
    input  opnd_t wr_b,
    input  logic  bc_valid,
    input  tag_t  bc_tag,
    input  data_t bc_data,
    input  logic  go,
    output logic  busy,
    output logic  cand,
    output op_t   op,
    output opnd_t a,
    output opnd_t b
);
    logic exec;

    // Slot state: fill on issue, capture on broadcast, free on own tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            exec <= 1'b0;
        end else if (wr_en) begin
            busy <= 1'b1;
            exec <= 1'b0;
            op   <= wr_op;
            a    <= snoop(wr_a, bc_valid, bc_tag, bc_data);
            b    <= snoop(wr_b, bc_valid, bc_tag, bc_data);
        end else if (busy) begin
            if (bc_valid && (bc_tag == MY_TAG)) begin
                busy <= 1'b0;
            end
            if (go) begin
                exec <= 1'b1;
            end
            a <= snoop(a, bc_valid, bc_tag, bc_data);
            b <= snoop(b, bc_valid, bc_tag, bc_data);
        end
    end

    // Candidate for dispatch: occupied, not yet sent, both values present.
    assign cand = busy && !exec && a.rdy && b.rdy;
endmodule

// File: rtl/rs_age_pick.sv
// Age matrix and oldest-first select. older[i][j] set means slot i entered
// before slot j. Assumes at most one alloc bit per cycle.
module rs_age_pick #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N-1:0] older [N];
    logic [N-1:0] blocked;

    // Matrix update: a newly filled slot becomes younger than all others.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) older[i] <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (alloc[k]) begin
                    older[k] <= '0;
                    for (int j = 0; j < N; j++) begin
                        if (j != k) older[j][k] <= 1'b1;
                    end
                end
            end
        end
    end

    // Select: a request wins unless an older slot also requests.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && req[j] && older[j][i]) blocked[i] = 1'b1;
            end
        end
        grant = req & ~blocked;
    end
endmodule

// File: rtl/rs_free_find.sv
// Finds the lowest-index free slot. Assumes busy reflects registered state.
module rs_free_find #(
    parameter int unsigned N     = 3,
    parameter int unsigned IDX_W = 2
) (
    input  logic [N-1:0]     busy,
    output logic [N-1:0]     first,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Priority scan from index zero upward.
    always_comb begin
        first = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!busy[i] && !any) begin
                first[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_pool.sv
// Pool of reservation slots for one execution unit. Slot i answers to tag
// TAG_BASE+i. Accepts one issue per cycle, snoops one broadcast bus and
// offers the oldest ready slot each cycle. Assumes the unit always accepts
// the offer and that TAG_BASE+N_ENT fits in TAG_W bits.
module rs_pool
    import rs_pool_pkg::*;
#(
    parameter int unsigned N_ENT    = 3,
    parameter int unsigned TAG_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic              iss_a_rdy,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic              iss_b_rdy,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              dsp_valid,
    output logic [OP_W-1:0]   dsp_op,
    output logic [TAG_W-1:0]  dsp_tag,
    output logic [DATA_W-1:0] dsp_a,
    output logic [DATA_W-1:0] dsp_b
);
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    logic [N_ENT-1:0] busy;
    logic [N_ENT-1:0] cand;
    logic [N_ENT-1:0] grant;
    logic [N_ENT-1:0] first_free;
    logic [N_ENT-1:0] alloc;
    logic [IDX_W-1:0] free_idx;
    logic             fire;
    op_t              s_op [N_ENT];
    opnd_t            s_a  [N_ENT];
    opnd_t            s_b  [N_ENT];
    opnd_t            in_a;
    opnd_t            in_b;

    assign in_a  = '{rdy: iss_a_rdy, tag: iss_a_tag, val: iss_a_val};
    assign in_b  = '{rdy: iss_b_rdy, tag: iss_b_tag, val: iss_b_val};
    assign fire  = iss_valid && iss_ready;
    assign alloc = first_free & {N_ENT{fire}};

    rs_free_find #(.N(N_ENT), .IDX_W(IDX_W)) u_free (
        .busy  (busy),
        .first (first_free),
        .idx   (free_idx),
        .any   (iss_ready)
    );

    assign iss_tag = tag_t'(TAG_BASE + free_idx);

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        rs_slot #(.MY_TAG(tag_t'(TAG_BASE + g))) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (alloc[g]),
            .wr_op    (iss_op),
            .wr_a     (in_a),
            .wr_b     (in_b),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_data  (bc_data),
            .go       (grant[g]),
            .busy     (busy[g]),
            .cand     (cand[g]),
            .op       (s_op[g]),
            .a        (s_a[g]),
            .b        (s_b[g])
        );
    end

    rs_age_pick #(.N(N_ENT)) u_age (
        .clk   (clk),
        .rst_n (rst_n),
        .alloc (alloc),
        .req   (cand),
        .grant (grant)
    );

    // Dispatch mux: OR together the fields of the single granted slot.
    always_comb begin
        dsp_valid = |grant;
        dsp_op    = '0;
        dsp_tag   = '0;
        dsp_a     = '0;
        dsp_b     = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (grant[i]) begin
                dsp_op  = dsp_op | s_op[i];
                dsp_tag = dsp_tag | tag_t'(TAG_BASE + i);
                dsp_a   = dsp_a | s_a[i].val;
                dsp_b   = dsp_b | s_b[i].val;
            end
        end
    end
endmodule

// File: rtl/rs_pool_chk.sv
// Property checker for rs_pool, attached by bind. Observes ports and the
// grant vector between the select and the slots.
module rs_pool_chk
    import rs_pool_pkg::*;
#(
    parameter int unsigned N_ENT    = 3,
    parameter int unsigned TAG_BASE = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic             iss_ready,
    input tag_t             iss_tag,
    input logic             bc_valid,
    input tag_t             bc_tag,
    input logic             dsp_valid,
    input tag_t             dsp_tag,
    input logic [N_ENT-1:0] grant
);
    // R9
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3
    no_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dsp_valid && iss_valid && iss_ready && (dsp_tag == iss_tag)));

    // R9
    no_redispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid |=> !(dsp_valid && (dsp_tag == $past(dsp_tag))));

    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_ready && bc_valid && (int'(bc_tag) >= TAG_BASE)
         && (int'(bc_tag) < TAG_BASE + N_ENT)) |=> iss_ready);

    // R2
    issue_tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_ready |-> ((int'(iss_tag) >= TAG_BASE)
                       && (int'(iss_tag) < TAG_BASE + N_ENT)));
endmodule

bind rs_pool rs_pool_chk #(.N_ENT(N_ENT), .TAG_BASE(TAG_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_tag   (iss_tag),
    .bc_valid  (bc_valid),
    .bc_tag    (bc_tag),
    .dsp_valid (dsp_valid),
    .dsp_tag   (dsp_tag),
    .grant     (grant)
);

// File: tb/test_rs_pool.sv
// Scoreboard bench: issue tasks queue the expected dispatches, a monitor
// compares every offered operation against the queue head.
module test_rs_pool;
    import rs_pool_pkg::*;

    typedef struct packed {
        op_t   op;
        tag_t  tag;
        data_t a;
        data_t b;
    } item_t;

    logic  clk = 1'b0;
    logic  rst_n = 1'b0;
    logic  iss_valid = 1'b0;
    op_t   iss_op = '0;
    logic  iss_a_rdy = 1'b0, iss_b_rdy = 1'b0;
    tag_t  iss_a_tag = '0, iss_b_tag = '0;
    data_t iss_a_val = '0, iss_b_val = '0;
    logic  iss_ready;
    tag_t  iss_tag;
    logic  bc_valid = 1'b0;
    tag_t  bc_tag = '0;
    data_t bc_data = '0;
    logic  dsp_valid;
    op_t   dsp_op;
    tag_t  dsp_tag;
    data_t dsp_a, dsp_b;

    int    n_cmp = 0;
    int    n_bad = 0;
    item_t exp_q [$];

    always #2 clk = ~clk;

    rs_pool i_rs_pool (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a_rdy(iss_a_rdy), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
        .iss_b_rdy(iss_b_rdy), .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .dsp_valid(dsp_valid), .dsp_op(dsp_op), .dsp_tag(dsp_tag),
        .dsp_a(dsp_a), .dsp_b(dsp_b)
    );

    task automatic chk(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // One clock: step past the edge, then drop the one-cycle strobes.
    task automatic tick();
        @(posedge clk);
        #1;
        iss_valid = 1'b0;
        bc_valid  = 1'b0;
    endtask

    task automatic set_bc(input tag_t t, input data_t d);
        bc_valid = 1'b1;
        bc_tag   = t;
        bc_data  = d;
    endtask

    // Drive one issue and check the slot tag it will take (R2).
    task automatic issue(input op_t op, input tag_t exp_tag,
                         input logic ar, input tag_t at, input data_t av,
                         input logic br, input tag_t bt, input data_t bv);
        chk(iss_ready == 1'b1, "R2 ready", 64'(iss_ready), 64'd1);
        chk(iss_tag == exp_tag, "R2 tag", 64'(iss_tag), 64'(exp_tag));
        iss_valid = 1'b1; iss_op = op;
        iss_a_rdy = ar; iss_a_tag = at; iss_a_val = av;
        iss_b_rdy = br; iss_b_tag = bt; iss_b_val = bv;
    endtask

    task automatic expect_d(input op_t op, input tag_t t, input data_t a,
                            input data_t b);
        exp_q.push_back('{op: op, tag: t, a: a, b: b});
    endtask

    // Monitor: every offered operation must match the queue head.
    always @(negedge clk) begin
        if (rst_n && dsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected dispatch", 64'(dsp_tag), 64'd0);
            end else begin
                item_t e;
                item_t g;
                e = exp_q.pop_front();
                g = '{op: dsp_op, tag: dsp_tag, a: dsp_a, b: dsp_b};
                chk(g == e, "R8 dispatch order/content", 64'(g), 64'(e));
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk(iss_ready == 1'b1, "R1 ready", 64'(iss_ready), 64'd1);
        chk(iss_tag == 3'd1, "R1 tag", 64'(iss_tag), 64'd1);
        chk(dsp_valid == 1'b0, "R1 dispatch", 64'(dsp_valid), 64'd0);

        // R3: ready operands dispatch the cycle after issue
        expect_d(2'd0, 3'd1, 16'd10, 16'd20);
        issue(2'd0, 3'd1, 1'b1, 3'd0, 16'd10, 1'b1, 3'd0, 16'd20);
        chk(dsp_valid == 1'b0, "R3 not in issue cycle", 64'(dsp_valid), 64'd0);
        tick();
        chk(dsp_valid && dsp_tag == 3'd1, "R3 dispatch", 64'(dsp_tag), 64'd1);
        tick();
        chk(dsp_valid == 1'b0, "R9 no repeat", 64'(dsp_valid), 64'd0);
        chk(iss_tag == 3'd2, "R2 lowest free", 64'(iss_tag), 64'd2);
        set_bc(3'd1, 16'd99); tick();
        chk(iss_tag == 3'd1, "R10 freed", 64'(iss_tag), 64'd1);

        // Fill the pool with waiting operations
        issue(2'd1, 3'd1, 1'b1, 3'd0, 16'd5, 1'b0, 3'd5, 16'd0); tick();
        issue(2'd2, 3'd2, 1'b0, 3'd6, 16'd0, 1'b1, 3'd0, 16'd7); tick();
        issue(2'd3, 3'd3, 1'b1, 3'd0, 16'd1, 1'b0, 3'd5, 16'd0); tick();
        chk(iss_ready == 1'b0, "R2 full", 64'(iss_ready), 64'd0);
        chk(dsp_valid == 1'b0, "R6 waiting", 64'(dsp_valid), 64'd0);
        // R2 refused issue, R4 non-matching tag
        iss_valid = 1'b1; iss_op = 2'd3; iss_a_rdy = 1'b1; iss_b_rdy = 1'b1;
        iss_a_val = 16'hdead; iss_b_val = 16'hbeef;
        set_bc(3'd7, 16'd50); tick();
        chk(dsp_valid == 1'b0, "R4 no match", 64'(dsp_valid), 64'd0);
        // R4/R7 capture of the last operand
        expect_d(2'd2, 3'd2, 16'd60, 16'd7);
        set_bc(3'd6, 16'd60);
        chk(dsp_valid == 1'b0, "R7 not in capture cycle", 64'(dsp_valid), 64'd0);
        tick();
        chk(dsp_valid && dsp_tag == 3'd2, "R7 dispatch", 64'(dsp_tag), 64'd2);
        expect_d(2'd1, 3'd1, 16'd5, 16'd70);
        expect_d(2'd3, 3'd3, 16'd1, 16'd70);
        set_bc(3'd5, 16'd70); tick();
        chk(dsp_tag == 3'd1, "R8 older first", 64'(dsp_tag), 64'd1);
        tick();
        chk(dsp_tag == 3'd3, "R9 next", 64'(dsp_tag), 64'd3);
        tick();
        chk(dsp_valid == 1'b0, "R9 drained", 64'(dsp_valid), 64'd0);
        set_bc(3'd2, 16'd0); tick();
        set_bc(3'd1, 16'd0); tick();
        set_bc(3'd3, 16'd0); tick();
        chk(iss_ready && iss_tag == 3'd1, "R10 all free", 64'(iss_tag), 64'd1);

        // R8: older slot at a higher index; R5 capture in the issue cycle
        expect_d(2'd0, 3'd1, 16'd3, 16'd4);
        issue(2'd0, 3'd1, 1'b1, 3'd0, 16'd3, 1'b1, 3'd0, 16'd4); tick();
        issue(2'd1, 3'd2, 1'b0, 3'd6, 16'd0, 1'b1, 3'd0, 16'd8); tick();
        set_bc(3'd1, 16'd0); tick();
        issue(2'd2, 3'd1, 1'b1, 3'd0, 16'd9, 1'b0, 3'd6, 16'd0); tick();
        expect_d(2'd1, 3'd2, 16'd33, 16'd8);
        expect_d(2'd2, 3'd1, 16'd9, 16'd33);
        expect_d(2'd3, 3'd3, 16'd33, 16'd11);
        issue(2'd3, 3'd3, 1'b0, 3'd6, 16'd0, 1'b1, 3'd0, 16'd11);
        set_bc(3'd6, 16'd33); tick();
        chk(dsp_tag == 3'd2, "R8 oldest at higher index", 64'(dsp_tag), 64'd2);
        tick();
        chk(dsp_tag == 3'd1, "R8 second", 64'(dsp_tag), 64'd1);
        tick();
        chk(dsp_valid && dsp_tag == 3'd3, "R5 issue-cycle capture", 64'(dsp_tag), 64'd3);
        tick();
        set_bc(3'd2, 16'd0); tick();
        set_bc(3'd1, 16'd0); tick();
        set_bc(3'd3, 16'd0); tick();
        chk(iss_ready == 1'b1, "R10 free at end", 64'(iss_ready), 64'd1);
        chk(exp_q.size() == 0, "R6 all expected dispatched", 64'(exp_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule